// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO

This block is a single-clock FIFO. The oldest stored word sits on the data outputs as soon as it exists, and no read request is needed to fetch it. Both handshake flags are active low. A "data available" flag is low while a valid word is shown. A "space available" flag is low while at least one location is free.

Because of this polarity, identical instances chain with no glue logic. The data output of one stage feeds the data input of the next. Its data-available flag drives the next stage's write enable. The next stage's space-available flag drives its read enable. Words ripple toward the last stage and free slots move back toward the first. A chain of stages holds the sum of their depths.

A synchronous active-high master reset empties the block. Capacity `DEPTH` counts the presentation register at the outputs plus `DEPTH-1` internal storage slots.

Top module: `cfifo_cascade`

## Requirements
- R1: In the cycle after a clock edge that samples `mrst` high, `or_n` is 1 and `ir_n` is 0.
- R2: A word accepted by an empty FIFO appears on `dout` at the very next clock edge, with `or_n` low, and no read request is needed.
- R3: `or_n` is 0 exactly when the FIFO holds at least one word. Reading the only stored word drives `or_n` high after that edge.
- R4: `ir_n` is 0 exactly when fewer than `DEPTH` words are held. After the `DEPTH`-th accepted write, `ir_n` goes to 1.
- R5: A write attempted while `ir_n` is 1 is ignored. The words already held and their order are unchanged.
- R6: A read attempted while `or_n` is 1 is ignored. A later write still falls through correctly.
- R7: Words leave in the order they were written. Reading a valid word while more are stored presents the next word at the following edge, and `or_n` stays low.
- R8: A read and a write in the same cycle, when the FIFO is neither empty nor full, leave the occupancy unchanged and keep the order.
- R9: While `oe` is 0, `dout` is all zeros. `oe` has no effect on the stored state or the flags.
- R10: Two instances chained as described form one FIFO of capacity 2*`DEPTH` that keeps order. On an empty chain, the first word reaches the last stage's outputs two edges after it is written.
- R11: Asserting `mrst` in the middle of traffic discards all held words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| mrst | input | 1 | Synchronous master reset, active high |
| din | input | WIDTH | Write data |
| wen_n | input | 1 | Write request, active low |
| ir_n | output | 1 | Space available, active low |
| dout | output | WIDTH | Presented word, zero while `oe` is 0 |
| ren_n | input | 1 | Read (consume presented word), active low |
| oe | input | 1 | Output enable, active high |
| or_n | output | 1 | Data available, active low |

## Verification
On every cycle, the assertions check several flag rules:
- An empty FIFO that takes a write shows data next cycle.
- A full FIFO that is not read stays full.
- The two flags are never both inactive.
- A read with stored words behind it keeps data available.
- Internal storage never overflows or underflows.

Only the bench's scenarios can show the actual word values and their order. The same holds for the effect of writes rejected while full, the zeroed outputs with `oe` low, and the combined depth and first-word latency of a two-stage chain.

// File: rtl/cfifo_pkg.sv
`timescale 1ns/1ps
package cfifo_pkg;

    // What the presentation register does on the coming edge
    typedef enum logic [1:0] {
        HEAD_HOLD     = 2'd0,
        HEAD_LOAD_MEM = 2'd1,
        HEAD_LOAD_IN  = 2'd2,
        HEAD_DRAIN    = 2'd3
    } head_op_e;

    // Pointer advance with wrap for storage sizes that are not a power of two
    function automatic int unsigned wrap_inc(input int unsigned cur, input int unsigned last);
        return (cur == last) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/cfifo_store.sv
`timescale 1ns/1ps
module cfifo_store #(
    parameter int WIDTH = 9,
    parameter int SLOTS = 15
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CW = $clog2(SLOTS + 1);
    localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

    logic [WIDTH-1:0] slot_q [SLOTS];
    logic [PW-1:0]    wptr_q, rptr_q, wptr_nx, rptr_nx;
    logic [CW-1:0]    cnt_q;

    // Pointer increment: free wrap when the slot count is a power of two
    generate
        if ((1 << PW) == SLOTS) begin : g_pow2
            assign wptr_nx = wptr_q + PW'(1);
            assign rptr_nx = rptr_q + PW'(1);
        end else begin : g_wrap
            assign wptr_nx = PW'(cfifo_pkg::wrap_inc(32'(wptr_q), 32'(LAST)));
            assign rptr_nx = PW'(cfifo_pkg::wrap_inc(32'(rptr_q), 32'(LAST)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push) slot_q[wptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wptr_q <= wptr_nx;
            if (pop)  rptr_q <= rptr_nx;
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = slot_q[rptr_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(SLOTS));

    p_store_no_overflow_r5: assert property (@(posedge clk) disable iff (mrst)
        (full && !pop) |-> !push);
    p_store_no_underflow_r6: assert property (@(posedge clk) disable iff (mrst)
        empty |-> !pop);

endmodule

// File: rtl/cfifo_head.sv
`timescale 1ns/1ps
module cfifo_head #(
    parameter int WIDTH = 9
) (
    input  logic                clk,
    input  logic                mrst,
    input  cfifo_pkg::head_op_e op,
    input  logic [WIDTH-1:0]    mem_word,
    input  logic [WIDTH-1:0]    in_word,
    output logic [WIDTH-1:0]    word,
    output logic                valid
);
    import cfifo_pkg::*;

    always_ff @(posedge clk) begin
        if (mrst) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            unique case (op)
                HEAD_LOAD_MEM: begin word <= mem_word; valid <= 1'b1; end
                HEAD_LOAD_IN:  begin word <= in_word;  valid <= 1'b1; end
                HEAD_DRAIN:    valid <= 1'b0;
                default:       valid <= valid;
            endcase
        end
    end

endmodule

// File: rtl/cfifo_cascade.sv
`timescale 1ns/1ps
module cfifo_cascade #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic [WIDTH-1:0] din,
    input  logic             wen_n,
    output logic             ir_n,
    output logic [WIDTH-1:0] dout,
    input  logic             ren_n,
    input  logic             oe,
    output logic             or_n
);
    import cfifo_pkg::*;

    localparam int SLOTS = (DEPTH > 1) ? DEPTH - 1 : 1;

    logic             head_valid, store_empty, store_full;
    logic             wr_fire, rd_fire, head_free, push, pop, full;
    logic [WIDTH-1:0] head_word, mem_word;
    head_op_e         op;

    assign full    = head_valid && store_full;
    assign wr_fire = !wen_n && !full;
    assign rd_fire = !ren_n && head_valid;
    assign head_free = !head_valid || rd_fire;

    // Refill the presentation register: storage first, then bypass from the input
    always_comb begin
        op = HEAD_HOLD;
        if (head_free) begin
            if (!store_empty)  op = HEAD_LOAD_MEM;
            else if (wr_fire)  op = HEAD_LOAD_IN;
            else if (rd_fire)  op = HEAD_DRAIN;
        end
    end

    assign push = wr_fire && (op != HEAD_LOAD_IN);
    assign pop  = (op == HEAD_LOAD_MEM);

    cfifo_store #(.WIDTH(WIDTH), .SLOTS(SLOTS)) u_store (
        .clk   (clk),
        .mrst  (mrst),
        .push  (push),
        .pop   (pop),
        .wdata (din),
        .rdata (mem_word),
        .empty (store_empty),
        .full  (store_full)
    );

    cfifo_head #(.WIDTH(WIDTH)) u_head (
        .clk      (clk),
        .mrst     (mrst),
        .op       (op),
        .mem_word (mem_word),
        .in_word  (din),
        .word     (head_word),
        .valid    (head_valid)
    );

    assign ir_n = full;
    assign or_n = !head_valid;
    assign dout = oe ? head_word : '0;

    p_empty_write_r2: assert property (@(posedge clk) disable iff (mrst)
        (or_n && !wen_n) |=> !or_n);
    p_empty_hold_r6: assert property (@(posedge clk) disable iff (mrst)
        (or_n && wen_n) |=> or_n);
    p_full_hold_r5: assert property (@(posedge clk) disable iff (mrst)
        (ir_n && ren_n) |=> ir_n);
    p_full_valid_r4: assert property (@(posedge clk) disable iff (mrst)
        ir_n |-> !or_n);
    p_read_advance_r7: assert property (@(posedge clk) disable iff (mrst)
        (!or_n && !ren_n && !store_empty) |=> !or_n);

endmodule

// File: tb/cfifo_cascade_bench.sv
`timescale 1ns/1ps
module cfifo_cascade_bench;
    localparam int W = 9;
    localparam int D = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         mrst = 1'b1;
    logic [W-1:0] din = '0;
    logic         wen_n = 1'b1, ren_n = 1'b1, oe = 1'b1;
    logic [W-1:0] dout;
    logic         ir_n, or_n;

    cfifo_cascade #(.WIDTH(W), .DEPTH(D)) u_cfifo_cascade (
        .clk(clk), .mrst(mrst), .din(din), .wen_n(wen_n), .ir_n(ir_n),
        .dout(dout), .ren_n(ren_n), .oe(oe), .or_n(or_n)
    );

    // Two-stage chain
    logic [W-1:0] c_din = '0, mid_data, c_dout;
    logic         c_wen_n = 1'b1, c_ren_n = 1'b1;
    logic         c_ir_n, mid_or_n, back_ir_n, c_or_n;

    cfifo_cascade #(.WIDTH(W), .DEPTH(D)) u_chain0 (
        .clk(clk), .mrst(mrst), .din(c_din), .wen_n(c_wen_n), .ir_n(c_ir_n),
        .dout(mid_data), .ren_n(back_ir_n), .oe(1'b1), .or_n(mid_or_n)
    );
    cfifo_cascade #(.WIDTH(W), .DEPTH(D)) u_chain1 (
        .clk(clk), .mrst(mrst), .din(mid_data), .wen_n(mid_or_n), .ir_n(back_ir_n),
        .dout(c_dout), .ren_n(c_ren_n), .oe(1'b1), .or_n(c_or_n)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [W-1:0] model [$];

    task automatic chk(input bit ok, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%0d expected=%0d", what, got, exp);
        end
    endtask

    // Drive one cycle at a negedge, update the model for the coming edge, check at the next negedge
    task automatic step(input bit rst, input bit w_n, input bit r_n, input bit en,
                        input logic [W-1:0] d, input string ctx);
        bit wr, rd;
        mrst = rst; wen_n = w_n; ren_n = r_n; oe = en; din = d;
        if (rst) model.delete();
        else begin
            wr = !w_n && (model.size() < D);
            rd = !r_n && (model.size() > 0);
            if (rd) void'(model.pop_front());
            if (wr) model.push_back(d);
        end
        @(posedge clk);
        @(negedge clk);
        chk(or_n == (model.size() == 0), {ctx, " or_n R3"}, int'(or_n), int'(model.size() == 0));
        chk(ir_n == (model.size() == D), {ctx, " ir_n R4"}, int'(ir_n), int'(model.size() == D));
        if (!oe) chk(dout == '0, {ctx, " dout zero R9"}, int'(dout), 0);
        else if (model.size() > 0) chk(dout == model[0], {ctx, " dout order R7"}, int'(dout), int'(model[0]));
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        step(1, 1, 1, 1, '0, "R1 reset");
        step(0, 1, 1, 1, '0, "R1 idle after reset");
        // R2 fall-through without read
        step(0, 0, 1, 1, 9'h1A5, "R2 first word");
        chk(dout == 9'h1A5 && !or_n, "R2 fall-through data", int'(dout), 9'h1A5);
        // R6 read while empty ignored
        step(0, 1, 0, 1, '0, "R6 drain");
        step(0, 1, 0, 1, '0, "R6 read empty");
        step(0, 1, 0, 0, '0, "R6 read empty oe low");
        step(0, 0, 1, 1, 9'h033, "R6 write after empty read");
        chk(dout == 9'h033, "R6 no underflow", int'(dout), 9'h033);
        // R4 fill and R5 write while full
        for (int i = 0; i < D; i++) step(0, 0, 1, 1, 9'(i + 40), "R4 fill");
        chk(ir_n == 1'b1, "R4 full flag", int'(ir_n), 1);
        step(0, 0, 1, 1, 9'h1FF, "R5 write while full");
        step(0, 0, 1, 0, 9'h1FE, "R5 write while full oe low R9");
        // R8 simultaneous read and write
        step(0, 1, 0, 1, '0, "R8 make room");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 9'(i + 200), "R8 read+write");
        for (int i = 0; i < D + 1; i++) step(0, 1, 0, 1, '0, "R7 drain");
        // Random traffic
        for (int i = 0; i < 600; i++) begin
            int wp, rp;
            wp = (i % 200 < 100) ? 70 : 30;
            rp = 100 - wp;
            step(0, !(($urandom % 100) < wp), !(($urandom % 100) < rp),
                 (($urandom % 10) != 0), W'($urandom), "random");
        end
        // R11 reset mid-stream
        step(0, 0, 1, 1, 9'h055, "R11 preload");
        step(0, 0, 1, 1, 9'h066, "R11 preload");
        step(1, 0, 1, 1, 9'h077, "R11 reset");
        chk(or_n == 1'b1, "R11 emptied", int'(or_n), 1);
        step(0, 1, 1, 1, '0, "R11 stays empty");

        // R10 chain: ripple latency of first word
        begin
            int acc, got, lat;
            c_din = 9'd100; c_wen_n = 1'b0;
            @(posedge clk); @(negedge clk);
            c_wen_n = 1'b1;
            lat = 1;
            while (c_or_n && lat < 10) begin @(posedge clk); @(negedge clk); lat++; end
            chk(lat == 2, "R10 ripple latency", lat, 2);
            acc = 1;
            for (int k = 0; k < 40; k++) begin
                bit take;
                take = !c_ir_n;
                c_din = 9'(100 + acc); c_wen_n = 1'b0;
                @(posedge clk);
                if (take) acc++;
                @(negedge clk);
            end
            c_wen_n = 1'b1;
            chk(acc == 2 * D, "R10 chain depth", acc, 2 * D);
            chk(c_ir_n == 1'b1, "R10 chain full flag", int'(c_ir_n), 1);
            got = 0;
            c_ren_n = 1'b0;
            for (int k = 0; k < 40; k++) begin
                if (!c_or_n) begin
                    chk(c_dout == 9'(100 + got), "R10 chain order", int'(c_dout), 100 + got);
                    got++;
                end
                @(posedge clk); @(negedge clk);
            end
            c_ren_n = 1'b1;
            chk(got == 2 * D, "R10 chain reads", got, 2 * D);
            chk(c_or_n == 1'b1, "R10 chain empty", int'(c_or_n), 1);
        end
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

endmodule